// File: doc/BRIEF.md
# Byte/Serial Synthesizer Configuration Loader

This block collects a 40-bit synthesizer configuration and hands it to the frequency synthesizer. The configuration is a 32-bit frequency tuning word plus an 8-bit control byte. The control byte holds a 5-bit phase offset, a power-down flag and a 2-bit load-format field. Data enters on a word-load strobe, either a whole byte at a time from an 8-bit bus or one bit at a time from a single serial pin. Each accepted load goes into a staging register at the position a load pointer names.

The synthesizer never sees the staging register directly. A separate update strobe copies the staged configuration into the active register, which drives the output ports, and returns the load pointer to its first position. Both strobes are sampled in the system clock domain and act on their rising edge only. The load format in force is the format field of the active register. This field therefore changes only through an update, and it switches between the two formats.

Top module: `dds_cfg_loader`

## Requirements
- R1: After reset is asserted and released, the tuning word, phase word, power-down flag and format field all read zero, and byte-wide (parallel) loading is in force.
- R2: In parallel mode five byte loads fill the configuration. The first byte is the control byte, with bits [7:3] the phase word, bit 2 power-down and bits [1:0] the format field. The second to fifth bytes are the tuning word from its most significant byte down to its least significant byte.
- R3: When the active format field equals 2'b11, loading is serial. Forty 1-bit loads from the serial pin fill the configuration: tuning word bit 0 first, up to tuning word bit 31, then control byte bit 0 up to control byte bit 7 last. Any other format value selects parallel loading.
- R4: The output ports change only in the cycle after a rising edge of the update strobe has been sampled. Loads on their own leave the outputs unchanged.
- R5: A sampled rising edge of the update strobe copies the whole staged configuration to the outputs one clock later and returns the load pointer to the first position.
- R6: Once the pointer has passed the final position (five in parallel mode, forty in serial mode), further loads are ignored and leave the staged data unchanged until the next update or reset.
- R7: Each strobe acts once per rising edge. A strobe held high over several clocks counts as a single load or a single update.
- R8: An update after a partial load transfers the newly written positions together with the previous contents of the positions not rewritten. The next load then goes to the first position.
- R9: A reset in the middle of a load sequence discards the pointer position, so a full sequence after reset is placed correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| wload | input | 1 | Word-load strobe, acts on its rising edge |
| fq_upd | input | 1 | Update strobe, acts on its rising edge |
| pdata | input | 8 | Byte bus for parallel loads |
| sdata | input | 1 | Serial data pin for serial loads |
| tuning_word | output | 32 | Active frequency tuning word |
| phase_word | output | 5 | Active phase offset |
| power_down | output | 1 | Active power-down flag |
| load_fmt | output | 2 | Active load-format field |

## Verification
Some behaviours are checked on every cycle by the assertions. These are the pointer bound and the freezing of staged data once the pointer is saturated. They also cover the one-cycle width of every detected strobe event and the stability of the active register between updates. Other behaviours can only be shown by the bench scenarios, because they depend on what was sent and what arrives at the outputs. These are the byte order and bit order of each format, the field split of the control byte, and the entry into and exit from serial mode. The same applies to the merge of a partial load with older staged data, and to recovery from a reset in the middle of a sequence.

// File: rtl/dds_cfg_pkg.sv
package dds_cfg_pkg;

  localparam int TW_W   = 32;
  localparam int PH_W   = 5;
  localparam int FMT_W  = 2;
  localparam int BYTE_W = 8;
  localparam int CTRL_W = PH_W + 1 + FMT_W;
  localparam int CFG_W  = CTRL_W + TW_W;
  localparam int PAR_LOADS = CFG_W / BYTE_W;
  localparam int SER_LOADS = CFG_W;
  localparam int PTR_W  = $clog2(SER_LOADS + 1);

  localparam logic [FMT_W-1:0] FMT_SERIAL = 2'b11;

  // Bit k of this struct is staging position k of a serial load.
  typedef struct packed {
    logic [PH_W-1:0]  phase;
    logic             pdown;
    logic [FMT_W-1:0] fmt;
    logic [TW_W-1:0]  tw;
  } cfg_t;

endpackage

// File: rtl/dds_rst_sync.sv
module dds_rst_sync (
  input  logic clk,
  input  logic rst_n_async,
  output logic rst_n_sync
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_async) begin
    if (!rst_n_async) sync_q <= 2'b00;
    else              sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];

endmodule

// File: rtl/dds_strobe_edge.sv
module dds_strobe_edge #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] strb_in,
  output logic [N-1:0] evt
);

  logic [N-1:0] prev_q;

  for (genvar i = 0; i < N; i++) begin : g_edge
    assign evt[i] = strb_in[i] & ~prev_q[i];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q[i] <= 1'b0;
      else        prev_q[i] <= strb_in[i];
    end

    AST_EVT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      evt[i] |=> !evt[i]); // R7
  end

endmodule

// File: rtl/dds_cfg_stager.sv
module dds_cfg_stager
  import dds_cfg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_evt,
  input  logic              upd_evt,
  input  logic              serial_mode,
  input  logic [BYTE_W-1:0] pbyte,
  input  logic              sbit,
  output cfg_t              staged
);

  logic [PTR_W-1:0] ptr_q, ptr_d;
  logic [CFG_W-1:0] stg_q, stg_d;
  logic [PTR_W-1:0] limit;
  logic             accept;

  assign limit  = serial_mode ? PTR_W'(SER_LOADS) : PTR_W'(PAR_LOADS);
  assign accept = load_evt && !upd_evt && (ptr_q < limit);

  always_comb begin
    ptr_d = ptr_q;
    stg_d = stg_q;
    if (upd_evt) begin
      ptr_d = '0;
    end else if (accept) begin
      ptr_d = ptr_q + 1'b1;
      if (serial_mode) begin
        for (int k = 0; k < SER_LOADS; k++)
          if (ptr_q == PTR_W'(k)) stg_d[k] = sbit;
      end else begin
        for (int j = 0; j < PAR_LOADS; j++)
          if (ptr_q == PTR_W'(j)) stg_d[CFG_W-1-j*BYTE_W -: BYTE_W] = pbyte;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
      stg_q <= '0;
    end else begin
      ptr_q <= ptr_d;
      stg_q <= stg_d;
    end
  end

  assign staged = cfg_t'(stg_q);

  AST_PTR_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_q <= limit); // R6
  AST_SAT_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr_q == limit && !upd_evt) |=> $stable(stg_q)); // R6
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !load_evt |=> $stable(stg_q)); // R4

endmodule

// File: rtl/dds_cfg_active.sv
module dds_cfg_active
  import dds_cfg_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic upd_evt,
  input  cfg_t staged,
  output cfg_t active
);

  cfg_t act_q, act_d;

  always_comb begin
    act_d = act_q;
    if (upd_evt) act_d = staged;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) act_q <= '0;
    else        act_q <= act_d;
  end

  assign active = act_q;

  AST_ACTIVE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_evt |=> $stable(act_q)); // R4

endmodule

// File: rtl/dds_cfg_loader.sv
module dds_cfg_loader
  import dds_cfg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wload,
  input  logic              fq_upd,
  input  logic [BYTE_W-1:0] pdata,
  input  logic              sdata,
  output logic [TW_W-1:0]   tuning_word,
  output logic [PH_W-1:0]   phase_word,
  output logic              power_down,
  output logic [FMT_W-1:0]  load_fmt
);

  logic       rst_n_s;
  logic [1:0] evt;
  cfg_t       staged;
  cfg_t       active;

  dds_rst_sync u_rst (
    .clk         (clk),
    .rst_n_async (rst_n),
    .rst_n_sync  (rst_n_s)
  );

  dds_strobe_edge #(.N(2)) u_edge (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .strb_in ({fq_upd, wload}),
    .evt     (evt)
  );

  dds_cfg_stager u_stage (
    .clk         (clk),
    .rst_n       (rst_n_s),
    .load_evt    (evt[0]),
    .upd_evt     (evt[1]),
    .serial_mode (active.fmt == FMT_SERIAL),
    .pbyte       (pdata),
    .sbit        (sdata),
    .staged      (staged)
  );

  dds_cfg_active u_act (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .upd_evt (evt[1]),
    .staged  (staged),
    .active  (active)
  );

  assign tuning_word = active.tw;
  assign phase_word  = active.phase;
  assign power_down  = active.pdown;
  assign load_fmt    = active.fmt;

  AST_OUT_STABLE: assert property (@(posedge clk) disable iff (!rst_n_s)
    !(fq_upd && !$past(fq_upd)) |=> $stable(tuning_word)); // R4

endmodule

// File: tb/dds_cfg_loader_bench.sv
module dds_cfg_loader_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wload, fq_upd, sdata;
  logic [7:0]  pdata;
  logic [31:0] tuning_word;
  logic [4:0]  phase_word;
  logic        power_down;
  logic [1:0]  load_fmt;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  dds_cfg_loader u_dds_cfg_loader (
    .clk(clk), .rst_n(rst_n), .wload(wload), .fq_upd(fq_upd),
    .pdata(pdata), .sdata(sdata), .tuning_word(tuning_word),
    .phase_word(phase_word), .power_down(power_down), .load_fmt(load_fmt)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic load_byte(input logic [7:0] b, input int hold = 1);
    @(negedge clk);
    pdata = b; wload = 1'b1;
    repeat (hold) @(negedge clk);
    wload = 1'b0;
  endtask

  task automatic load_bit(input logic b);
    @(negedge clk);
    sdata = b; wload = 1'b1;
    @(negedge clk);
    wload = 1'b0;
  endtask

  task automatic update(input int hold = 1);
    @(negedge clk);
    fq_upd = 1'b1;
    repeat (hold) @(negedge clk);
    fq_upd = 1'b0;
  endtask

  task automatic load_par(input logic [7:0] ctrl, input logic [31:0] tw);
    load_byte(ctrl);
    for (int i = 3; i >= 0; i--) load_byte(tw[i*8 +: 8]);
  endtask

  task automatic load_ser(input logic [7:0] ctrl, input logic [31:0] tw);
    logic [39:0] v;
    v = {ctrl, tw};
    for (int k = 0; k < 40; k++) load_bit(v[k]);
  endtask

  task automatic expect_cfg(input string req, input logic [7:0] ctrl, input logic [31:0] tw);
    chk({req, " tuning"}, tuning_word, tw);
    chk({req, " phase"}, 32'(phase_word), 32'(ctrl[7:3]));
    chk({req, " pdown"}, 32'(power_down), 32'(ctrl[2]));
    chk({req, " fmt"}, 32'(load_fmt), 32'(ctrl[1:0]));
  endtask

  task automatic t_reset();
    do_reset();
    expect_cfg("R1 reset", 8'h00, 32'h0);
  endtask

  task automatic t_parallel();
    load_par(8'hAD, 32'h12345678);
    repeat (2) @(negedge clk);
    chk("R4 no update yet", tuning_word, 32'h0);
    update();
    expect_cfg("R2 R5 parallel", 8'hAD, 32'h12345678);
    repeat (3) @(negedge clk);
    chk("R4 held after update", tuning_word, 32'h12345678);
  endtask

  task automatic t_extra_byte();
    load_par(8'h48, 32'hCAFEF00D);
    load_byte(8'hFF);
    update();
    expect_cfg("R6 sixth byte ignored", 8'h48, 32'hCAFEF00D);
  endtask

  task automatic t_held_strobe();
    load_byte(8'h10, 4);
    for (int i = 1; i <= 4; i++) load_byte(8'(i));
    update(3);
    expect_cfg("R7 held strobe", 8'h10, 32'h01020304);
  endtask

  task automatic t_partial();
    load_byte(8'h20);
    load_byte(8'hAA);
    update();
    expect_cfg("R8 partial merge", 8'h20, 32'hAA020304);
    load_par(8'h30, 32'h11223344);
    update();
    expect_cfg("R8 pointer restart", 8'h30, 32'h11223344);
  endtask

  task automatic t_reset_mid();
    load_byte(8'h77);
    load_byte(8'h66);
    do_reset();
    expect_cfg("R9 R1 reset mid", 8'h00, 32'h0);
    load_par(8'h58, 32'h0A0B0C0D);
    update();
    expect_cfg("R9 after reset", 8'h58, 32'h0A0B0C0D);
  endtask

  task automatic t_serial();
    load_par(8'h03, 32'h0);
    update();
    chk("R3 enter serial fmt", 32'(load_fmt), 32'h3);
    load_ser(8'h9B, 32'hDEADBEEF);
    update();
    expect_cfg("R3 serial load", 8'h9B, 32'hDEADBEEF);
    load_ser(8'h24, 32'h0000FFFF);
    load_bit(1'b1);
    update();
    expect_cfg("R3 R6 serial exit", 8'h24, 32'h0000FFFF);
    load_par(8'h00, 32'h87654321);
    update();
    expect_cfg("R3 parallel again", 8'h00, 32'h87654321);
  endtask

  initial begin
    rst_n = 1'b0; wload = 1'b0; fq_upd = 1'b0; sdata = 1'b0; pdata = 8'h00;
    t_reset();
    t_parallel();
    t_extra_byte();
    t_held_strobe();
    t_partial();
    t_reset_mid();
    t_serial();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule